// File: doc/BRIEF.md
# Four-Bank Bilinear Interpolation Datapath

This block turns one 2x2 pixel neighbourhood per clock into a single bilinearly interpolated output pixel. The image is stored across four interleaved memory banks. Bank index bit 0 selects the horizontal parity and bit 1 selects the vertical parity, so bank A=0, B=1, C=2 and D=3. All four banks are read in the same cycle. The block receives the four bank pixels, a 4-bit sub-pixel fraction for each axis, and the least significant bit of the integer X and Y coordinates.

The two integer LSBs tell which bank holds the upper-left pixel of the group. The fractions measure distance from that pixel, so the block works out each bank's spatial position relative to it. It then derives the matching weight from a coefficient table, multiplies the four pixels by their weights and adds the products. The sum is rounded to an 8-bit result.

The coefficient values are computed from their defining products whenever a lookup is made. No stored table is loaded. The datapath accepts a new neighbourhood on every cycle and has a fixed latency.

Top module: `bilerp_datapath`

## Requirements
- R1: While `rst_ni` is low, and after it is released until valid data reaches the output, `valid_o` is 0 and `pix_o` is 0.
- R2: `valid_o` repeats `valid_i` exactly 3 rising edges later. An input applied before edge k appears after edge k+2.
- R3: When lsb_x=0 and lsb_y=0, bank A is upper-left. The weights, in units of 1/256, are A=(16-fx)(16-fy), B=fx(16-fy), C=(16-fx)fy and D=fx·fy.
- R4: When lsb_x=1 and lsb_y=0, bank B is upper-left. The weights are B=(16-fx)(16-fy), A=fx(16-fy), D=(16-fx)fy and C=fx·fy.
- R5: When lsb_x=0 and lsb_y=1, bank C is upper-left. The weights are C=(16-fx)(16-fy), D=fx(16-fy), A=(16-fx)fy and B=fx·fy.
- R6: When lsb_x=1 and lsb_y=1, bank D is upper-left. The weights are D=(16-fx)(16-fy), C=fx(16-fy), B=(16-fx)fy and A=fx·fy. With both fractions 0, the output equals the upper-left bank's pixel.
- R7: The four weights always add up to 256. When all four pixels are equal, the output equals that pixel value.
- R8: The output is (sum of pixel·weight + 128) >> 8. The result never exceeds the largest of the four input pixels.
- R9: Back-to-back valid inputs each produce one output on consecutive cycles, with no bubbles.
- R10: `pix_o` holds its last value on any cycle where `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input neighbourhood is valid |
| pix_i | input | 32 | Bank pixels, A in bits 7:0, B 15:8, C 23:16, D 31:24 |
| frac_x_i | input | 4 | Horizontal sub-pixel fraction, 0..15 |
| frac_y_i | input | 4 | Vertical sub-pixel fraction, 0..15 |
| lsb_x_i | input | 1 | Integer X coordinate LSB |
| lsb_y_i | input | 1 | Integer Y coordinate LSB |
| valid_o | output | 1 | Interpolated output is valid |
| pix_o | output | 8 | Interpolated pixel |

## Verification
The hardest situation to reach is a bank/weight misrouting that only shows up for particular combinations of parity and fraction. Such an error hides whenever the pixels are equal or the fractions are symmetric.

To expose it, the stimulus walks all 1024 combinations of fractions and parity LSBs back to back. Each combination gets fresh random, distinct pixel values. A spatial reference model then locates the upper-left, right, lower and diagonal pixels independently of bank naming.

Directed zero-fraction cases with four distinct pixels pin each parity case to its upper-left bank. Sparse pixels at half-step fractions land exactly on the rounding threshold.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;
  typedef enum logic [1:0] {BANK_A = 2'd0, BANK_B = 2'd1, BANK_C = 2'd2, BANK_D = 2'd3} bank_e;
  localparam int unsigned NUM_BANKS = 4;
endpackage

// File: rtl/bilerp_coef.sv
module bilerp_coef
  import bilerp_pkg::*;
#(
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned W_W   = 2 * FRAC_W + 1,
  localparam int unsigned IDX_W = 2 * FRAC_W + 2
) (
  input  logic [IDX_W-1:0]               idx_i,  // {lsb_y, lsb_x, frac_y, frac_x}
  output logic [NUM_BANKS-1:0][W_W-1:0]  w_o
);
  localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;

  logic [FRAC_W-1:0] fx, fy;
  logic [1:0]        ul;
  assign fx = idx_i[FRAC_W-1:0];
  assign fy = idx_i[2*FRAC_W-1:FRAC_W];
  assign ul = idx_i[IDX_W-1:2*FRAC_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [1:0]    rel;  // spatial position of this bank relative to upper-left
    logic [FRAC_W:0] hx, hy;
    assign rel = 2'(b) ^ ul;
    assign hx  = rel[0] ? {1'b0, fx} : ONE - {1'b0, fx};
    assign hy  = rel[1] ? {1'b0, fy} : ONE - {1'b0, fy};
    assign w_o[b] = W_W'(hx * hy);
  end
endmodule

// File: rtl/bilerp_mac.sv
module bilerp_mac
  import bilerp_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned W_W   = 2 * FRAC_W + 1,
  localparam int unsigned SH    = 2 * FRAC_W,
  localparam int unsigned ACC_W = PIX_W + W_W + 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [NUM_BANKS-1:0][PIX_W-1:0] pix_i,
  input  logic [NUM_BANKS-1:0][W_W-1:0]   w_i,
  output logic                            valid_o,
  output logic [PIX_W-1:0]                pix_o
);
  logic                            v_q;
  logic [NUM_BANKS-1:0][PIX_W-1:0] p_q;
  logic [NUM_BANKS-1:0][W_W-1:0]   w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      p_q <= '0;
      w_q <= '0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        p_q <= pix_i;
        w_q <= w_i;
      end
    end
  end

  logic [NUM_BANKS-1:0][ACC_W-1:0] prod;
  logic [ACC_W-1:0]                acc;
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mul
    assign prod[b] = ACC_W'(p_q[b]) * ACC_W'(w_q[b]);
  end

  always_comb begin
    acc = ACC_W'(1) << (SH - 1);  // rounding half
    for (int b = 0; b < NUM_BANKS; b++) acc = acc + prod[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= v_q;
      if (v_q) pix_o <= PIX_W'(acc >> SH);
    end
  end

  logic [W_W+1:0]   w_sum;
  logic [PIX_W-1:0] p_max;
  always_comb begin
    w_sum = '0;
    p_max = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      w_sum = w_sum + (W_W+2)'(w_q[b]);
      if (p_q[b] > p_max) p_max = p_q[b];
    end
  end

  // R7
  weight_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q |-> w_sum == ((W_W+2)'(1) << SH));

  // R8
  no_overshoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q |=> pix_o <= $past(p_max));
endmodule

// File: rtl/bilerp_datapath.sv
module bilerp_datapath
  import bilerp_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned W_W   = 2 * FRAC_W + 1,
  localparam int unsigned IDX_W = 2 * FRAC_W + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [NUM_BANKS*PIX_W-1:0] pix_i,
  input  logic [FRAC_W-1:0]          frac_x_i,
  input  logic [FRAC_W-1:0]          frac_y_i,
  input  logic                       lsb_x_i,
  input  logic                       lsb_y_i,
  output logic                       valid_o,
  output logic [PIX_W-1:0]           pix_o
);
  logic                            s1_v;
  logic [NUM_BANKS-1:0][PIX_W-1:0] s1_pix;
  logic [IDX_W-1:0]                s1_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_pix <= '0;
      s1_idx <= '0;
    end else begin
      s1_v <= valid_i;
      if (valid_i) begin
        s1_pix <= pix_i;
        s1_idx <= {lsb_y_i, lsb_x_i, frac_y_i, frac_x_i};
      end
    end
  end

  logic [NUM_BANKS-1:0][W_W-1:0] w;

  bilerp_coef #(.FRAC_W(FRAC_W)) u_coef (
    .idx_i (s1_idx),
    .w_o   (w)
  );

  bilerp_mac #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_v),
    .pix_i   (s1_pix),
    .w_i     (w),
    .valid_o (valid_o),
    .pix_o   (pix_o)
  );

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i, 3) |-> valid_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pix_o));
endmodule

// File: tb/bilerp_datapath_bench.sv
module bilerp_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] pix_i = '0;
  logic [3:0]  fx_i = '0, fy_i = '0;
  logic        lx_i = 1'b0, ly_i = 1'b0;
  logic        valid_o;
  logic [7:0]  pix_o;

  int total = 0, bad = 0;
  bit done = 0;
  bit    q_v[$];
  int    q_d[$];
  string q_r[$];
  int    last_d = 0;

  always #2 clk = ~clk;  // 250 MHz

  bilerp_datapath u_bilerp_datapath (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .pix_i(pix_i),
    .frac_x_i(fx_i), .frac_y_i(fy_i), .lsb_x_i(lx_i), .lsb_y_i(ly_i),
    .valid_o(valid_o), .pix_o(pix_o)
  );

  function automatic int bank_pix(logic [31:0] p, int b);
    return int'(p[b*8 +: 8]);
  endfunction

  // Spatial model: locate neighbours from the upper-left bank, then blend.
  function automatic int ref_out(logic [31:0] p, int fx, int fy, int lx, int ly);
    int ul = ly * 2 + lx;
    int p00 = bank_pix(p, ul);
    int p10 = bank_pix(p, ul ^ 1);
    int p01 = bank_pix(p, ul ^ 2);
    int p11 = bank_pix(p, ul ^ 3);
    int s = p00 * (16 - fx) * (16 - fy) + p10 * fx * (16 - fy)
          + p01 * (16 - fx) * fy + p11 * fx * fy;
    return (s + 128) / 256;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] p, int fx, int fy, int lx, int ly, string req);
    @(negedge clk);
    if (q_v.size() == 3) begin
      bit    ev = q_v.pop_front();
      int    ed = q_d.pop_front();
      string er = q_r.pop_front();
      chk({er, "/R2 valid"}, int'(valid_o), int'(ev));
      if (ev) begin
        chk(er, int'(pix_o), ed);
        last_d = ed;
      end else chk("R10 hold", int'(pix_o), last_d);
    end
    valid_i = v;
    pix_i = p;
    fx_i = 4'(fx);
    fy_i = 4'(fy);
    lx_i = lx[0];
    ly_i = ly[0];
    q_v.push_back(v);
    q_d.push_back(ref_out(p, fx, fy, lx, ly));
    q_r.push_back(req);
  endtask

  function automatic string case_tag(int lx, int ly);
    if (!lx && !ly) return "R3";
    if (lx && !ly) return "R4";
    if (!lx && ly) return "R5";
    return "R6";
  endfunction

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 data in reset", int'(pix_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(valid_o), 0);
    // zero fractions: output is the upper-left bank pixel
    for (int c = 0; c < 4; c++)
      step(1, 32'h40302010, 0, 0, c & 1, c >> 1, case_tag(c & 1, c >> 1));
    // asymmetric fractions per parity case
    for (int c = 0; c < 4; c++)
      step(1, 32'hF0A05010, 3, 11, c & 1, c >> 1, case_tag(c & 1, c >> 1));
    // R10: gaps with valid low
    for (int i = 0; i < 4; i++) step(0, $urandom, i, i, 0, 0, "R10");
    // R8 rounding threshold: 1*128+128 -> 1, 1*112+128 -> 0
    step(1, 32'h00000100, 8, 0, 0, 0, "R8 up");
    step(1, 32'h00000100, 7, 0, 0, 0, "R8 down");
    step(1, 32'hFFFFFFFF, 15, 15, 1, 1, "R8 max");
    // R7 equal pixels
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v = 8'($urandom);
      step(1, {4{v}}, i * 2, 15 - i, i & 1, (i >> 1) & 1, "R7");
    end
    // R9 full back-to-back sweep of all 1024 address combinations
    for (int a = 0; a < 1024; a++) begin
      int lx = (a >> 8) & 1;
      int ly = (a >> 9) & 1;
      step(1, $urandom, a & 15, (a >> 4) & 15, lx, ly, {case_tag(lx, ly), "/R9"});
    end
    // random with sporadic gaps
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom);
      step(((r >> 20) & 3) != 0, $urandom, r & 15, (r >> 4) & 15,
           (r >> 8) & 1, (r >> 9) & 1, "R10/R9 mix");
    end
    for (int i = 0; i < 4; i++) step(0, '0, 0, 0, 0, 0, "R2 drain");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule